// File: doc/BRIEF.md
# Flash chip-select address decoder

This block turns a flash access address into a device selection for a controller that can drive up to four serial flash devices. The devices sit on two buses, A and B, each with two chip selects. Four programmable top-address limits split the flash address space into consecutive windows, one per device. The block returns the bus, the chip select on that bus and the byte offset inside the selected device. An address outside every window raises an out-of-range flag.

Two request channels share the same limits and are decoded in parallel. One channel carries memory-mapped reads. The other carries the start address of an indirectly issued command. A small write port loads the limits.

A build parameter sets how the memory-mapped base address is treated:
- In one variant the limits and incoming addresses include the base.
- In the other variant the base is removed inside the block, and the limits are relative to it.

Top module: `flash_cs_decoder`

## Requirements
- R1: After reset every result output is zero. Limit k (k = 1..4) resets to k*WIN_SIZE, plus MAP_BASE when BASE_INTERNAL = 0.
- R2: An effective address from the lower bound up to, but not including, limit 1 selects bus A chip 1. The outputs are bus = 0 and cs = 2'b01, and the offset is the address minus the lower bound.
- R3: An effective address at or above limit 1 and below limit 2 selects bus A chip 2. The outputs are bus = 0 and cs = 2'b10, and the offset is the address minus limit 1.
- R4: An effective address at or above limit 2 and below limit 3 selects bus B chip 1. The outputs are bus = 1 and cs = 2'b01, and the offset is the address minus limit 2.
- R5: An effective address at or above limit 3 and below limit 4 selects bus B chip 2. The outputs are bus = 1 and cs = 2'b10, and the offset is the address minus limit 3.
- R6: An effective address below the lower bound, or at or above limit 4, sets the out-of-range flag. In that case bus, cs and offset are all zero.
- R7: If the limits are not ascending, the lowest-numbered window whose limit lies above the address wins.
- R8: A cycle with cfg_we_i high loads cfg_data_i into limit cfg_sel_i + 1 (selector 0 = bus A chip 1, 1 = A2, 2 = B1, 3 = B2). A decode in that same cycle still uses the old limit, and the new limit applies from the next cycle.
- R9: With BASE_INTERNAL = 1, the effective address is the address minus MAP_BASE (modulo 2^ADDR_W) and the lower bound is 0. With BASE_INTERNAL = 0, the effective address is the address itself and the lower bound is MAP_BASE.
- R10: A valid output rises in the cycle after its request and equals the request valid of the previous cycle.
- R11: In cycles with no request on a channel, that channel's bus, cs, offset and flag keep their last values.
- R12: The read channel and the command channel decode independently and in the same cycle against the same limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Limit write strobe |
| cfg_sel_i | input | 2 | Limit index: 0 = A1, 1 = A2, 2 = B1, 3 = B2 |
| cfg_data_i | input | ADDR_W | Limit value to write |
| rd_valid_i | input | 1 | Memory-mapped read request |
| rd_addr_i | input | ADDR_W | Memory-mapped read address |
| cmd_valid_i | input | 1 | Indirect command request |
| cmd_addr_i | input | ADDR_W | Indirect command start address |
| rd_vld_o | output | 1 | Read result valid |
| rd_bus_o | output | 1 | Read: 0 = bus A, 1 = bus B |
| rd_cs_o | output | 2 | Read: one-hot chip select on the bus |
| rd_ofs_o | output | ADDR_W | Read: offset inside the device |
| rd_oor_o | output | 1 | Read: address outside all windows |
| cmd_vld_o | output | 1 | Command result valid |
| cmd_bus_o | output | 1 | Command: 0 = bus A, 1 = bus B |
| cmd_cs_o | output | 2 | Command: one-hot chip select on the bus |
| cmd_ofs_o | output | ADDR_W | Command: offset inside the device |
| cmd_oor_o | output | 1 | Command: address outside all windows |

## Verification
A limit write and a decode can land in the same cycle. The bench provokes this by asserting cfg_we_i on limit 1 in the same cycle as a read request whose address lies between the old and the new limit. It then expects the old window (bus A chip 1) on the result, and the new window (bus A chip 2) when the same address is repeated one cycle later. Both channels also decode every cycle of the address sweeps, each with a different address. Every result is compared with an arithmetic model of the windows, under default, reprogrammed and non-ascending limits, and in both base variants.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int unsigned NUM_DEV = 4;
  localparam int unsigned NUM_CH  = 2;

  typedef enum logic [2:0] {
    WIN_A1   = 3'd0,
    WIN_A2   = 3'd1,
    WIN_B1   = 3'd2,
    WIN_B2   = 3'd3,
    WIN_NONE = 3'd4
  } win_e;
endpackage

// File: rtl/fcs_limit_regs.sv
module fcs_limit_regs
  import fcs_pkg::*;
#(
  parameter int unsigned        ADDR_W        = 32,
  parameter int unsigned        WIN_SIZE      = 1024,
  parameter logic [ADDR_W-1:0]  MAP_BASE      = '0,
  parameter bit                 BASE_INTERNAL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic [ADDR_W-1:0] lim_o [NUM_DEV]
);
  localparam logic [ADDR_W-1:0] BASE_ADD = BASE_INTERNAL ? '0 : MAP_BASE;

  logic [ADDR_W-1:0] lim_q [NUM_DEV];

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_lim
    localparam logic [ADDR_W-1:0] RST_VAL = ADDR_W'((k + 1) * WIN_SIZE) + BASE_ADD;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           lim_q[k] <= RST_VAL;
      else if (we_i && sel_i == 2'(k))       lim_q[k] <= data_i;
    end
    assign lim_o[k] = lim_q[k];
  end

  // R8: written value visible the next cycle
  p_write_lands_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> lim_q[$past(sel_i)] == $past(data_i));
endmodule

// File: rtl/fcs_win_decode.sv
module fcs_win_decode
  import fcs_pkg::*;
#(
  parameter int unsigned        ADDR_W        = 32,
  parameter logic [ADDR_W-1:0]  MAP_BASE      = '0,
  parameter bit                 BASE_INTERNAL = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] lim_i [NUM_DEV],
  output win_e              win_o,
  output logic [ADDR_W-1:0] ofs_o
);
  logic [ADDR_W-1:0] eff;
  logic [ADDR_W-1:0] low;
  logic [ADDR_W-1:0] bound [NUM_DEV+1];
  logic [NUM_DEV-1:0] hit;

  if (BASE_INTERNAL) begin : g_int
    assign eff = addr_i - MAP_BASE;
    assign low = '0;
  end else begin : g_ext
    assign eff = addr_i;
    assign low = MAP_BASE;
  end

  assign bound[0] = low;
  for (genvar k = 0; k < NUM_DEV; k++) begin : g_cmp
    assign bound[k+1] = lim_i[k];
    assign hit[k]     = eff < lim_i[k];
  end

  // lowest-numbered hit wins
  always_comb begin
    win_o = WIN_NONE;
    ofs_o = '0;
    if (eff >= low) begin
      for (int k = NUM_DEV - 1; k >= 0; k--) begin
        if (hit[k]) begin
          win_o = win_e'(k);
          ofs_o = eff - bound[k];
        end
      end
    end
  end
endmodule

// File: rtl/fcs_out_reg.sv
module fcs_out_reg
  import fcs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  win_e              win_i,
  input  logic [ADDR_W-1:0] ofs_i,
  output logic              vld_o,
  output logic              bus_o,
  output logic [1:0]        cs_o,
  output logic [ADDR_W-1:0] ofs_o,
  output logic              oor_o
);
  logic              bus_d;
  logic [1:0]        cs_d;
  logic [ADDR_W-1:0] ofs_d;
  logic              oor_d;

  always_comb begin
    bus_d = 1'b0;
    cs_d  = 2'b00;
    ofs_d = ofs_i;
    oor_d = 1'b0;
    unique case (win_i)
      WIN_A1:  cs_d = 2'b01;
      WIN_A2:  cs_d = 2'b10;
      WIN_B1:  begin bus_d = 1'b1; cs_d = 2'b01; end
      WIN_B2:  begin bus_d = 1'b1; cs_d = 2'b10; end
      default: begin oor_d = 1'b1; ofs_d = '0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      bus_o <= 1'b0;
      cs_o  <= 2'b00;
      ofs_o <= '0;
      oor_o <= 1'b0;
    end else begin
      vld_o <= valid_i;
      if (valid_i) begin
        bus_o <= bus_d;
        cs_o  <= cs_d;
        ofs_o <= ofs_d;
        oor_o <= oor_d;
      end
    end
  end

  p_lat_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> vld_o);
  p_lat_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !vld_o);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(bus_o) && $stable(cs_o) && $stable(ofs_o) && $stable(oor_o)));
  p_no_chip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oor_o |-> (cs_o == 2'b00 && !bus_o && ofs_o == '0));
  p_cs_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o) && (oor_o || !vld_o || $countones(cs_o) == 1));
endmodule

// File: rtl/flash_cs_decoder.sv
module flash_cs_decoder
  import fcs_pkg::*;
#(
  parameter int unsigned        ADDR_W        = 32,
  parameter int unsigned        WIN_SIZE      = 1024,
  parameter logic [ADDR_W-1:0]  MAP_BASE      = 32'h2000_0000,
  parameter bit                 BASE_INTERNAL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              cmd_valid_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  output logic              rd_vld_o,
  output logic              rd_bus_o,
  output logic [1:0]        rd_cs_o,
  output logic [ADDR_W-1:0] rd_ofs_o,
  output logic              rd_oor_o,
  output logic              cmd_vld_o,
  output logic              cmd_bus_o,
  output logic [1:0]        cmd_cs_o,
  output logic [ADDR_W-1:0] cmd_ofs_o,
  output logic              cmd_oor_o
);
  logic [ADDR_W-1:0] lim [NUM_DEV];

  logic              req_v   [NUM_CH];
  logic [ADDR_W-1:0] req_a   [NUM_CH];
  logic              res_vld [NUM_CH];
  logic              res_bus [NUM_CH];
  logic [1:0]        res_cs  [NUM_CH];
  logic [ADDR_W-1:0] res_ofs [NUM_CH];
  logic              res_oor [NUM_CH];

  fcs_limit_regs #(
    .ADDR_W(ADDR_W), .WIN_SIZE(WIN_SIZE),
    .MAP_BASE(MAP_BASE), .BASE_INTERNAL(BASE_INTERNAL)
  ) u_lim (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .data_i(cfg_data_i),
    .lim_o(lim)
  );

  assign req_v[0] = rd_valid_i;
  assign req_a[0] = rd_addr_i;
  assign req_v[1] = cmd_valid_i;
  assign req_a[1] = cmd_addr_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    win_e              win;
    logic [ADDR_W-1:0] ofs;

    fcs_win_decode #(
      .ADDR_W(ADDR_W), .MAP_BASE(MAP_BASE), .BASE_INTERNAL(BASE_INTERNAL)
    ) u_dec (
      .addr_i(req_a[c]), .lim_i(lim), .win_o(win), .ofs_o(ofs)
    );

    fcs_out_reg #(.ADDR_W(ADDR_W)) u_reg (
      .clk_i, .rst_ni,
      .valid_i(req_v[c]), .win_i(win), .ofs_i(ofs),
      .vld_o(res_vld[c]), .bus_o(res_bus[c]), .cs_o(res_cs[c]),
      .ofs_o(res_ofs[c]), .oor_o(res_oor[c])
    );
  end

  assign rd_vld_o  = res_vld[0];
  assign rd_bus_o  = res_bus[0];
  assign rd_cs_o   = res_cs[0];
  assign rd_ofs_o  = res_ofs[0];
  assign rd_oor_o  = res_oor[0];
  assign cmd_vld_o = res_vld[1];
  assign cmd_bus_o = res_bus[1];
  assign cmd_cs_o  = res_cs[1];
  assign cmd_ofs_o = res_ofs[1];
  assign cmd_oor_o = res_oor[1];

  // R12: equal requests on both channels give equal results
  p_ch_agree_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && cmd_valid_i && rd_addr_i == cmd_addr_i) |=>
      (rd_bus_o == cmd_bus_o && rd_cs_o == cmd_cs_o &&
       rd_ofs_o == cmd_ofs_o && rd_oor_o == cmd_oor_o));
endmodule

// File: tb/flash_cs_decoder_test.sv
`timescale 1ns/1ps
module flash_cs_decoder_test;
  localparam int unsigned AW   = 16;
  localparam int unsigned WIN  = 16;
  localparam logic [AW-1:0] BASE = 16'h0100;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_data = '0;
  logic          rd_v = 1'b0, cmd_v = 1'b0, i_rd_v = 1'b0;
  logic [AW-1:0] rd_a = '0, cmd_a = '0, i_rd_a = '0;

  logic rd_vld, rd_bus, rd_oor, cmd_vld, cmd_bus, cmd_oor;
  logic [1:0] rd_cs, cmd_cs;
  logic [AW-1:0] rd_ofs, cmd_ofs;
  logic i_vld, i_bus, i_oor, i_cvld, i_cbus, i_coor;
  logic [1:0] i_cs, i_ccs;
  logic [AW-1:0] i_ofs, i_cofs;

  flash_cs_decoder #(.ADDR_W(AW), .WIN_SIZE(WIN), .MAP_BASE(BASE), .BASE_INTERNAL(1'b0)) uut (
    .clk_i(clk), .rst_ni,
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .rd_valid_i(rd_v), .rd_addr_i(rd_a), .cmd_valid_i(cmd_v), .cmd_addr_i(cmd_a),
    .rd_vld_o(rd_vld), .rd_bus_o(rd_bus), .rd_cs_o(rd_cs), .rd_ofs_o(rd_ofs), .rd_oor_o(rd_oor),
    .cmd_vld_o(cmd_vld), .cmd_bus_o(cmd_bus), .cmd_cs_o(cmd_cs), .cmd_ofs_o(cmd_ofs), .cmd_oor_o(cmd_oor)
  );

  flash_cs_decoder #(.ADDR_W(AW), .WIN_SIZE(WIN), .MAP_BASE(BASE), .BASE_INTERNAL(1'b1)) uut_int (
    .clk_i(clk), .rst_ni,
    .cfg_we_i(1'b0), .cfg_sel_i(2'b00), .cfg_data_i('0),
    .rd_valid_i(i_rd_v), .rd_addr_i(i_rd_a), .cmd_valid_i(1'b0), .cmd_addr_i('0),
    .rd_vld_o(i_vld), .rd_bus_o(i_bus), .rd_cs_o(i_cs), .rd_ofs_o(i_ofs), .rd_oor_o(i_oor),
    .cmd_vld_o(i_cvld), .cmd_bus_o(i_cbus), .cmd_cs_o(i_ccs), .cmd_ofs_o(i_cofs), .cmd_oor_o(i_coor)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [AW-1:0] lim_m [4];
  logic [AW-1:0] lim_i [4];

  // Arithmetic model of the window map
  task automatic model(input logic [AW-1:0] addr, input bit internal, input logic [AW-1:0] l [4],
                       output logic e_bus, output logic [1:0] e_cs, output logic [AW-1:0] e_ofs,
                       output logic e_oor, output string tag);
    logic [AW-1:0] eff, low, prev;
    int w;
    eff  = internal ? addr - BASE : addr;
    low  = internal ? '0 : BASE;
    w    = 4;
    if (eff >= low)
      for (int k = 0; k < 4; k++)
        if (w == 4 && eff < l[k]) w = k;
    e_bus = 1'b0; e_cs = 2'b00; e_ofs = '0; e_oor = 1'b0;
    if (w == 4) begin e_oor = 1'b1; tag = "R6"; end
    else begin
      prev  = (w == 0) ? low : l[w-1];
      e_ofs = eff - prev;
      e_bus = (w >= 2);
      e_cs  = (w % 2 == 0) ? 2'b01 : 2'b10;
      tag   = (w == 0) ? "R2" : (w == 1) ? "R3" : (w == 2) ? "R4" : "R5";
    end
  endtask

  task automatic cmp(input string req, input logic a_vld, input logic a_bus, input logic [1:0] a_cs,
                     input logic [AW-1:0] a_ofs, input logic a_oor, input logic e_vld, input logic e_bus,
                     input logic [1:0] e_cs, input logic [AW-1:0] e_ofs, input logic e_oor);
    checks++;
    if ({a_vld, a_bus, a_cs, a_ofs, a_oor} !== {e_vld, e_bus, e_cs, e_ofs, e_oor}) begin
      errors++;
      $display("FAIL %s: actual vld=%0b bus=%0b cs=%b ofs=%h oor=%0b expected vld=%0b bus=%0b cs=%b ofs=%h oor=%0b",
               req, a_vld, a_bus, a_cs, a_ofs, a_oor, e_vld, e_bus, e_cs, e_ofs, e_oor);
    end
  endtask

  task automatic check_rd(input string ctx, input logic [AW-1:0] addr);
    logic b, o; logic [1:0] c; logic [AW-1:0] f; string t;
    model(addr, 1'b0, lim_m, b, c, f, o, t);
    cmp({t, " rd ", ctx}, rd_vld, rd_bus, rd_cs, rd_ofs, rd_oor, 1'b1, b, c, f, o);
  endtask

  task automatic check_cmd(input string ctx, input logic [AW-1:0] addr);
    logic b, o; logic [1:0] c; logic [AW-1:0] f; string t;
    model(addr, 1'b0, lim_m, b, c, f, o, t);
    cmp({t, " R12 cmd ", ctx}, cmd_vld, cmd_bus, cmd_cs, cmd_ofs, cmd_oor, 1'b1, b, c, f, o);
  endtask

  task automatic check_int(input logic [AW-1:0] addr);
    logic b, o; logic [1:0] c; logic [AW-1:0] f; string t;
    model(addr, 1'b1, lim_i, b, c, f, o, t);
    cmp({t, " R9 internal base"}, i_vld, i_bus, i_cs, i_ofs, i_oor, 1'b1, b, c, f, o);
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = val;
    @(negedge clk);
    cfg_we = 1'b0;
    lim_m[sel] = val;
  endtask

  // Both channels and the internal-base instance every cycle
  task automatic sweep(input string ctx, input int step);
    for (int a = 16'h00F0; a <= 16'h0150; a += step) begin
      rd_v = 1'b1; rd_a = AW'(a);
      cmd_v = 1'b1; cmd_a = AW'(16'h0250 - a);
      i_rd_v = 1'b1; i_rd_a = AW'(a);
      @(negedge clk);
      check_rd(ctx, AW'(a));
      check_cmd(ctx, AW'(16'h0250 - a));
      check_int(AW'(a));
    end
    rd_v = 1'b0; cmd_v = 1'b0; i_rd_v = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      lim_m[k] = AW'((k + 1) * WIN) + BASE;
      lim_i[k] = AW'((k + 1) * WIN);
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset outputs
    cmp("R1 reset rd", rd_vld, rd_bus, rd_cs, rd_ofs, rd_oor, 1'b0, 1'b0, 2'b00, '0, 1'b0);
    cmp("R1 reset cmd", cmd_vld, cmd_bus, cmd_cs, cmd_ofs, cmd_oor, 1'b0, 1'b0, 2'b00, '0, 1'b0);
    cmp("R1 reset int", i_vld, i_bus, i_cs, i_ofs, i_oor, 1'b0, 1'b0, 2'b00, '0, 1'b0);

    // R1 reset limits, R2..R6, R9, R12: full sweep with default limits
    sweep("R1 default limits", 1);

    // R10: valid rises exactly one cycle after the request
    rd_v = 1'b1; rd_a = 16'h0125;
    #1;
    cmp("R10 before edge", rd_vld, rd_bus, rd_cs, rd_ofs, rd_oor,
        1'b0, rd_bus, rd_cs, rd_ofs, rd_oor);
    @(negedge clk);
    check_rd("R10 after edge", 16'h0125);
    rd_v = 1'b0;
    // R11: fields hold while idle
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      cmp("R11 hold", rd_vld, rd_bus, rd_cs, rd_ofs, rd_oor, 1'b0, 1'b1, 2'b01, 16'h0005, 1'b0);
    end

    // R8: reprogram to uneven windows, then sweep
    cfg_write(2'd0, 16'h0108);
    cfg_write(2'd1, 16'h0118);
    cfg_write(2'd2, 16'h0130);
    cfg_write(2'd3, 16'h0140);
    sweep("R8 reprogrammed", 1);

    // R8: write and decode in the same cycle
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_data = 16'h0104;
    rd_v = 1'b1; rd_a = 16'h0106;
    @(negedge clk);
    cfg_we = 1'b0;
    cmp("R8 same-cycle old limit", rd_vld, rd_bus, rd_cs, rd_ofs, rd_oor, 1'b1, 1'b0, 2'b01, 16'h0006, 1'b0);
    @(negedge clk);
    cmp("R8 next-cycle new limit", rd_vld, rd_bus, rd_cs, rd_ofs, rd_oor, 1'b1, 1'b0, 2'b10, 16'h0002, 1'b0);
    lim_m[0] = 16'h0104;
    rd_v = 1'b0;
    @(negedge clk);

    // R7: non-ascending limits, lowest window wins
    cfg_write(2'd0, 16'h0140);
    sweep("R7 non-ascending", 4);
    rd_v = 1'b1; rd_a = 16'h0120;
    @(negedge clk);
    cmp("R7 A1 over A2", rd_vld, rd_bus, rd_cs, rd_ofs, rd_oor, 1'b1, 1'b0, 2'b01, 16'h0020, 1'b0);
    rd_v = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule